// File: doc/BRIEF.md
# Interrupt Cause and Summary Register Block

This block collects the event pulses that a bus sequencer produces and turns them into a single level-sensitive interrupt line for software. It has three interrupt sources: command complete, exception and error. The exception and error sources each have a sticky cause register that keeps every individual sub-cause. Each of those cause registers rolls up into one bit of a three-bit summary register. A mask register with the same three-bit layout decides which summary bits may drive the interrupt line. A masked source still shows in the summary register.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge at which the write strobe is seen. Read data is registered. Software acknowledges events by writing ones to summary bits. Clearing the exception or error summary bit also empties the cause register behind it. The mask is a separate register, so clearing never changes which sources are enabled. The sequencer also reports the completion of its own reset command through a dedicated pulse, which raises the command-complete bit so that software can poll for it.

Top module: `intr_cause_ctrl`

## Requirements
- R1: While reset (synchronous, active high) is applied, and after it is released, every register reads 0x00 and `irq_o` is low.
- R2: The summary register is at offset 0xA0. Its bit 0 is command complete, bit 1 is exception and bit 2 is error. Bits 7:3 read zero.
- R3: The exception cause register is at offset 0x70. Each bit of `evt_exc` sets the matching bit and stays set: 0x01 selection timeout, 0x02 phase mismatch, 0x04 arbitration lost, 0x08 reselected, 0x10 selected, 0x20 selected with attention. Summary bit 1 reads one whenever any exception cause bit is set.
- R4: The error cause register is at offset 0x80. Each bit of `evt_err` sets the matching bit and stays set: bits 3:0 parity, 0x10 sequence error, 0x20 bus reset seen, 0x40 unexpected disconnect. Bits from several pulses accumulate. Summary bit 2 reads one whenever any error cause bit is set.
- R5: The mask register is at offset 0x90 and uses the summary layout. A write stores bits 2:0 (0x07 enables all sources, 0x00 disables all). Reads return the stored bits, with bits 7:3 zero.
- R6: `irq_o` is high exactly when some summary bit and its mask bit are both one. It follows the register state on the same clock edge. Masking a source does not hide it in the summary register.
- R7: Writing a one to a summary bit clears it. A zero bit in the write leaves that summary bit unchanged. Clearing bit 1 or bit 2 clears the whole exception or error cause register.
- R8: If an event and a clear of the same source meet on one edge, the event wins. The newly pulsed bits stay set and the previously held bits are cleared.
- R9: A pulse on `evt_reset_done` sets summary bit 0, exactly as `evt_done` does.
- R10: Writes to the exception or error cause offsets leave both registers unchanged.
- R11: `reg_rdata` is registered. It shows the register addressed in the previous cycle, with the value that register held before that cycle's update. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| evt_done | input | 1 | Command complete pulse |
| evt_reset_done | input | 1 | Reset command complete pulse |
| evt_exc | input | 6 | Exception sub-cause pulses |
| evt_err | input | 7 | Error sub-cause pulses |
| irq_o | output | 1 | Level-sensitive interrupt output |

## Verification
Two functions of this block can meet on one edge: a new event pulse from the sequencer, and a write-one-to-clear from software to the same source. The bench provokes this by holding a clear write to the summary register and new exception and command-complete pulses in the same cycle, while an older exception cause is already held. It then reads back the cause and summary registers. The new cause bit must survive, the old one must be gone, and the command-complete bit must still be set. A second meeting point is a read whose data is captured on the same edge at which an event lands. The bench expects the value from before the update, and the new value one read later.

// File: rtl/intr_cause_pkg.sv
package intr_cause_pkg;
  // summary bit layout (software decodes these positions)
  localparam int SUM_W    = 3;
  localparam int SUM_DONE = 0;
  localparam int SUM_EXC  = 1;
  localparam int SUM_ERR  = 2;
  // register file entries seen by the read port
  localparam int NUM_REGS = 4;
endpackage

// File: rtl/intr_sticky_cause.sv
module intr_sticky_cause #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_next_o
);
  logic [W-1:0] q;

  // held bits drop on clear, new pulses are OR-ed in afterwards so they win
  always_comb q_next_o = (q & ~{W{clr_i}}) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next_o;
  end

  assign q_o = q;
endmodule

// File: rtl/intr_read_mux.sv
module intr_read_mux #(
  parameter int                     DATA_W = 8,
  parameter int                     ADDR_W = 8,
  parameter int                     N      = 4,
  parameter logic [N*ADDR_W-1:0]    OFFS   = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [N*DATA_W-1:0]   regs_i,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (addr_i == OFFS[i*ADDR_W +: ADDR_W])
        sel = sel | regs_i[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
  import intr_cause_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                EXC_W    = 6,
  parameter int                ERR_W    = 7,
  parameter logic [ADDR_W-1:0] SUM_OFS  = 8'hA0,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h90,
  parameter logic [ADDR_W-1:0] EXC_OFS  = 8'h70,
  parameter logic [ADDR_W-1:0] ERR_OFS  = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_done,
  input  logic              evt_reset_done,
  input  logic [EXC_W-1:0]  evt_exc,
  input  logic [ERR_W-1:0]  evt_err,
  output logic              irq_o
);
  localparam int SUM_PAD  = DATA_W - SUM_W;
  localparam int EXC_PAD  = DATA_W - EXC_W;
  localparam int ERR_PAD  = DATA_W - ERR_W;

  // write decode
  logic             wr_sum, wr_mask;
  logic [SUM_W-1:0] clr_vec;
  logic             unused_wdata_hi;

  assign wr_sum          = reg_wr && (reg_addr == SUM_OFS);
  assign wr_mask         = reg_wr && (reg_addr == MASK_OFS);
  assign clr_vec         = wr_sum ? reg_wdata[SUM_W-1:0] : '0;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SUM_W];

  // cause registers
  logic [EXC_W-1:0] exc_q, exc_next;
  logic [ERR_W-1:0] err_q, err_next;
  logic [0:0]       done_q, done_next;
  logic [0:0]       done_set;

  assign done_set = evt_done | evt_reset_done;

  intr_sticky_cause #(.W(EXC_W)) u_exc (
    .clk(clk), .rst(rst), .set_i(evt_exc), .clr_i(clr_vec[SUM_EXC]),
    .q_o(exc_q), .q_next_o(exc_next)
  );

  intr_sticky_cause #(.W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .set_i(evt_err), .clr_i(clr_vec[SUM_ERR]),
    .q_o(err_q), .q_next_o(err_next)
  );

  intr_sticky_cause #(.W(1)) u_done (
    .clk(clk), .rst(rst), .set_i(done_set), .clr_i(clr_vec[SUM_DONE]),
    .q_o(done_q), .q_next_o(done_next)
  );

  // summary is a roll-up of the cause registers
  logic [SUM_W-1:0] sum_q, sum_next;

  always_comb begin
    sum_q            = '0;
    sum_q[SUM_DONE]  = done_q[0];
    sum_q[SUM_EXC]   = |exc_q;
    sum_q[SUM_ERR]   = |err_q;
    sum_next           = '0;
    sum_next[SUM_DONE] = done_next[0];
    sum_next[SUM_EXC]  = |exc_next;
    sum_next[SUM_ERR]  = |err_next;
  end

  // mask register, kept apart from the clear path
  logic [SUM_W-1:0] mask_q, mask_next;

  assign mask_next = wr_mask ? reg_wdata[SUM_W-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next;
  end

  // registered interrupt, aligned with the register state
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sum_next & mask_next);
  end

  assign irq_o = irq_q;

  // read port
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  assign regs_flat = {
    {{SUM_PAD{1'b0}}, sum_q},
    {{SUM_PAD{1'b0}}, mask_q},
    {{EXC_PAD{1'b0}}, exc_q},
    {{ERR_PAD{1'b0}}, err_q}
  };

  intr_read_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N(NUM_REGS),
    .OFFS({SUM_OFS, MASK_OFS, EXC_OFS, ERR_OFS})
  ) u_rd (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .regs_i(regs_flat),
    .rdata_o(reg_rdata)
  );
endmodule

// File: rtl/intr_cause_ctrl_chk.sv
module intr_cause_ctrl_chk #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                EXC_W    = 6,
  parameter int                ERR_W    = 7,
  parameter int                SUM_W    = 3,
  parameter logic [ADDR_W-1:0] SUM_OFS  = 8'hA0,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h90,
  parameter logic [ADDR_W-1:0] EXC_OFS  = 8'h70
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              evt_done,
  input logic              evt_reset_done,
  input logic [EXC_W-1:0]  evt_exc,
  input logic [EXC_W-1:0]  exc_q,
  input logic [ERR_W-1:0]  err_q,
  input logic [SUM_W-1:0]  sum_q,
  input logic [SUM_W-1:0]  mask_q,
  input logic              irq_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (exc_q == '0 && err_q == '0 && sum_q == '0 && mask_q == '0 && !irq_o));

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(sum_q & mask_q));

  assert_mask_store_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == MASK_OFS) |=> mask_q == $past(reg_wdata[SUM_W-1:0]));

  assert_clear_exc_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SUM_OFS && reg_wdata[1] && evt_exc == '0) |=> exc_q == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_exc != '0) |=> ((exc_q & $past(evt_exc)) == $past(evt_exc)));

  assert_reset_done_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_reset_done || evt_done) |=> sum_q[0]);

  assert_exc_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == EXC_OFS && evt_exc == '0) |=> exc_q == $past(exc_q));
endmodule

bind intr_cause_ctrl intr_cause_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EXC_W(EXC_W), .ERR_W(ERR_W),
  .SUM_W(intr_cause_pkg::SUM_W),
  .SUM_OFS(SUM_OFS), .MASK_OFS(MASK_OFS), .EXC_OFS(EXC_OFS)
) chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .evt_done(evt_done), .evt_reset_done(evt_reset_done),
  .evt_exc(evt_exc), .exc_q(exc_q), .err_q(err_q), .sum_q(sum_q),
  .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/intr_cause_ctrl_tb_top.sv
`timescale 1ns/100ps
module intr_cause_ctrl_tb_top;
  localparam logic [7:0] A_SUM  = 8'hA0;
  localparam logic [7:0] A_MASK = 8'h90;
  localparam logic [7:0] A_EXC  = 8'h70;
  localparam logic [7:0] A_ERR  = 8'h80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       evt_done = 1'b0;
  logic       evt_reset_done = 1'b0;
  logic [5:0] evt_exc = '0;
  logic [6:0] evt_err = '0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  intr_cause_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
    .evt_reset_done(evt_reset_done), .evt_exc(evt_exc), .evt_err(evt_err),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_exc(input logic [5:0] v);
    @(negedge clk); evt_exc = v;
    @(negedge clk); evt_exc = '0;
  endtask

  task automatic pulse_err(input logic [6:0] v);
    @(negedge clk); evt_err = v;
    @(negedge clk); evt_err = '0;
  endtask

  task automatic t_reset();
    check("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    @(negedge clk); rst = 1'b0;
    expect_reg("R1 summary", A_SUM, 8'h00);
    expect_reg("R1 mask", A_MASK, 8'h00);
    expect_reg("R1 exception", A_EXC, 8'h00);
    expect_reg("R1 error", A_ERR, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_exc_masked();
    pulse_exc(6'h02);
    check("R6 masked irq low", {7'b0, irq_o}, 8'h00);
    expect_reg("R3 phase mismatch cause", A_EXC, 8'h02);
    expect_reg("R2 R6 summary shows masked exc", A_SUM, 8'h02);
  endtask

  task automatic t_mask();
    wr(A_MASK, 8'h07);
    check("R6 irq after enable", {7'b0, irq_o}, 8'h01);
    expect_reg("R5 mask readback", A_MASK, 8'h07);
    wr(A_MASK, 8'hF8);
    check("R6 irq after disable", {7'b0, irq_o}, 8'h00);
    expect_reg("R5 upper mask bits", A_MASK, 8'h00);
    wr(A_MASK, 8'h07);
  endtask

  task automatic t_ignored_writes();
    wr(A_EXC, 8'h3F);
    expect_reg("R10 exc write ignored", A_EXC, 8'h02);
    wr(A_ERR, 8'h7F);
    expect_reg("R10 err write ignored", A_ERR, 8'h00);
  endtask

  task automatic t_clear();
    wr(A_SUM, 8'h05);
    expect_reg("R7 zero bit keeps exc", A_EXC, 8'h02);
    wr(A_SUM, 8'h02);
    check("R7 irq after clear", {7'b0, irq_o}, 8'h00);
    expect_reg("R7 exc cause cleared", A_EXC, 8'h00);
    expect_reg("R7 summary cleared", A_SUM, 8'h00);
  endtask

  task automatic t_error();
    pulse_err(7'h41);
    pulse_err(7'h10);
    check("R6 irq on error", {7'b0, irq_o}, 8'h01);
    expect_reg("R4 error accumulates", A_ERR, 8'h51);
    expect_reg("R4 error summary", A_SUM, 8'h04);
    pulse_err(7'h2E);
    expect_reg("R4 reset and parity bits", A_ERR, 8'h7F);
    wr(A_SUM, 8'h04);
    expect_reg("R7 error cause cleared", A_ERR, 8'h00);
  endtask

  task automatic t_done_mask();
    @(negedge clk); evt_done = 1'b1;
    @(negedge clk); evt_done = 1'b0;
    check("R6 irq on done", {7'b0, irq_o}, 8'h01);
    expect_reg("R2 done summary", A_SUM, 8'h01);
    wr(A_MASK, 8'h06);
    check("R6 done masked", {7'b0, irq_o}, 8'h00);
    expect_reg("R11 unmapped 00", 8'h00, 8'h00);
    expect_reg("R11 unmapped F0", 8'hF0, 8'h00);
    wr(A_SUM, 8'h01);
    wr(A_MASK, 8'h07);
    expect_reg("R7 done cleared", A_SUM, 8'h00);
  endtask

  task automatic t_collision();
    pulse_exc(6'h04);
    @(negedge clk);
    reg_addr = A_SUM; reg_wdata = 8'h03; reg_wr = 1'b1;
    evt_exc = 6'h08; evt_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_exc = '0; evt_done = 1'b0;
    check("R8 irq after collision", {7'b0, irq_o}, 8'h01);
    expect_reg("R8 new cause kept old cleared", A_EXC, 8'h08);
    expect_reg("R8 summary after collision", A_SUM, 8'h03);
    wr(A_SUM, 8'h07);
    expect_reg("R7 clear all", A_SUM, 8'h00);
  endtask

  task automatic t_reset_done();
    @(negedge clk); evt_reset_done = 1'b1;
    @(negedge clk); evt_reset_done = 1'b0;
    expect_reg("R9 reset done sets bit 0", A_SUM, 8'h01);
    wr(A_SUM, 8'h01);
  endtask

  task automatic t_read_timing();
    logic [7:0] d;
    @(negedge clk); reg_addr = A_SUM; evt_done = 1'b1;
    @(negedge clk); evt_done = 1'b0; d = reg_rdata;
    check("R11 read shows pre-update value", d, 8'h00);
    @(negedge clk); d = reg_rdata;
    check("R11 next read shows update", d, 8'h01);
    wr(A_SUM, 8'h01);
  endtask

  task automatic t_midrun_reset();
    pulse_exc(6'h21);
    pulse_err(7'h01);
    check("R6 irq before reset", {7'b0, irq_o}, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    check("R1 rdata after reset", reg_rdata, 8'h00);
    expect_reg("R1 exc after reset", A_EXC, 8'h00);
    expect_reg("R1 err after reset", A_ERR, 8'h00);
    expect_reg("R1 mask after reset", A_MASK, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_exc_masked();
    t_mask();
    t_ignored_writes();
    t_clear();
    t_error();
    t_done_mask();
    t_collision();
    t_reset_done();
    t_read_timing();
    t_midrun_reset();
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule